// File: doc/BRIEF.md
# Three-Phase Deadtime Insertion and Cross-Conduction Interlock

This block turns filtered high-side and low-side switch commands into gate enables for the three legs of a bridge inverter. Each leg works on its own. When both commands of a leg are asserted, the leg holds both enables off. When one switch of a leg turns off and the other is then requested, the block makes sure a minimum deadtime has passed before the second switch turns on. The deadtime is a whole number of clock cycles.

The block lengthens only gaps that are too short. A controller that already leaves a gap as long as the minimum or longer gets its timing through unchanged. Both command paths go through the same number of register stages, so a rising or falling edge on either input reaches its enable after the same number of cycles. A switch that turns off and is asked to turn on again on the same side is not delayed by the deadtime. Only the opposite side is held back.

Top module: `dt_three_phase`

## Requirements
- R1: In every leg, the high-side enable and the low-side enable are never on in the same cycle.
- R2: In steady state, per leg, input pair (hin,lin) gives (ho_en,lo_en) as follows: 00 gives 00, 01 gives 01, 10 gives 10, 11 gives 00. Bit p of each vector belongs to leg p.
- R3: An enable follows its own input with a latency of exactly PIPE_STAGES+1 clock cycles. This latency is the same for rising and falling edges and for both sides.
- R4: If a leg's opposite command arrives G cycles after the first side's command dropped, and G is less than DT_CYCLES, the enable rises exactly DT_CYCLES cycles after the other enable fell. This holds in both directions.
- R5: If that gap G is at least DT_CYCLES, the enable rises exactly G cycles after the other enable fell, so the gap is unchanged.
- R6: When both commands are asserted while one side is on, that side turns off with normal latency. The deadtime count starts from that fall.
- R7: If both commands rise in the same cycle from the both-off state, neither enable turns on. When one command is later removed, the other side turns on with normal latency.
- R8: A side that turns off and is commanded on again is not delayed by the deadtime. A one-cycle off command gives a one-cycle off pulse on that enable.
- R9: The legs are independent. Different command pairs on different legs produce each leg's own truth-table result.
- R10: Reset clears both enables of every leg and leaves no deadtime pending, so the first command after reset appears with normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hin | input | NUM_PHASES | High-side commands, bit p for leg p |
| lin | input | NUM_PHASES | Low-side commands, bit p for leg p |
| ho_en | output | NUM_PHASES | High-side gate enables |
| lo_en | output | NUM_PHASES | Low-side gate enables |

## Verification
Within one leg, the turn-off of one side and the request for the other side can land in the same cycle. That is a zero-length gap, and an overlapped command is the negative-gap version of it. Here the interlock and the deadtime timer act together: the interlock holds the new side off because the old one is still on, and the timer then holds it for the full deadtime. The bench provokes this by sweeping the commanded gap from zero up past the deadtime in both directions, and with overlapped commands of short and long duration. In each case it measures, in cycles, the distance from the falling enable to the rising one and compares it with the larger of the commanded gap and the deadtime.

// File: rtl/dt_pkg.sv
package dt_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_cmd_t;

  typedef enum logic {
    SIDE_HI = 1'b0,
    SIDE_LO = 1'b1
  } side_e;

  // Counter width able to hold the deadtime value itself.
  function automatic int unsigned cnt_width(input int unsigned dt);
    int unsigned w;
    w = $clog2(dt + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Value loaded on a falling enable so that the opposite side rises
  // exactly dt cycles later.
  function automatic int unsigned reload_value(input int unsigned dt);
    return (dt == 0) ? 0 : dt - 1;
  endfunction

  // Gap seen at the outputs for a commanded gap of g cycles.
  function automatic int unsigned output_gap(input int unsigned g,
                                             input int unsigned dt);
    return (g < dt) ? dt : g;
  endfunction

endpackage

// File: rtl/dt_cmd_pipe.sv
module dt_cmd_pipe
  import dt_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_cmd_t cmd_in,
  output leg_cmd_t cmd_out
);

  // Both sides travel in one struct, so their depth is equal by build.
  generate
    if (STAGES == 0) begin : g_bypass
      assign cmd_out = cmd_in;
    end else begin : g_pipe
      leg_cmd_t stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
          stg[0] <= cmd_in;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign cmd_out = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dt_gap_timer.sv
module dt_gap_timer
  import dt_pkg::*;
#(
  parameter int unsigned DT_CYCLES = 29
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fell_hi,
  input  logic fell_lo,
  output logic block_hi,
  output logic block_lo
);

  localparam int unsigned CW = cnt_width(DT_CYCLES);
  localparam logic [CW-1:0] RELOAD = CW'(reload_value(DT_CYCLES));

  logic [CW-1:0] cnt_q;
  side_e         last_q;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= SIDE_HI;
    end else if (fell_hi) begin
      cnt_q  <= RELOAD;
      last_q <= SIDE_HI;
    end else if (fell_lo) begin
      cnt_q  <= RELOAD;
      last_q <= SIDE_LO;
    end else if (busy) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy     = (cnt_q != '0);
  // Only the side opposite to the one that fell is held back.
  assign block_hi = busy && (last_q == SIDE_LO);
  assign block_lo = busy && (last_q == SIDE_HI);

endmodule

// File: rtl/dt_interlock.sv
module dt_interlock
  import dt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  leg_cmd_t cmd,
  input  logic     block_hi,
  input  logic     block_lo,
  output logic     ho_q,
  output logic     lo_q,
  output logic     fell_hi,
  output logic     fell_lo
);

  logic ho_nx;
  logic lo_nx;
  logic only_hi;
  logic only_lo;

  assign only_hi = cmd.hi && !cmd.lo;
  assign only_lo = cmd.lo && !cmd.hi;

  // A side may stay on while commanded alone; it may come on only when
  // the other side is off and no deadtime holds it back.
  always_comb begin
    ho_nx = only_hi && !lo_q && (ho_q || !block_hi);
    lo_nx = only_lo && !ho_q && (lo_q || !block_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ho_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      ho_q <= ho_nx;
      lo_q <= lo_nx;
    end
  end

  assign fell_hi = ho_q && !ho_nx;
  assign fell_lo = lo_q && !lo_nx;

endmodule

// File: rtl/dt_leg.sv
module dt_leg
  import dt_pkg::*;
#(
  parameter int unsigned DT_CYCLES   = 29,
  parameter int unsigned PIPE_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hin,
  input  logic lin,
  output logic ho_en,
  output logic lo_en,
  output logic hs_stg,
  output logic ls_stg
);

  leg_cmd_t raw_cmd;
  leg_cmd_t stg_cmd;
  logic     fell_hi;
  logic     fell_lo;
  logic     block_hi;
  logic     block_lo;

  assign raw_cmd.hi = hin;
  assign raw_cmd.lo = lin;

  dt_cmd_pipe #(.STAGES(PIPE_STAGES)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_in  (raw_cmd),
    .cmd_out (stg_cmd)
  );

  dt_interlock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (stg_cmd),
    .block_hi (block_hi),
    .block_lo (block_lo),
    .ho_q     (ho_en),
    .lo_q     (lo_en),
    .fell_hi  (fell_hi),
    .fell_lo  (fell_lo)
  );

  dt_gap_timer #(.DT_CYCLES(DT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .fell_hi  (fell_hi),
    .fell_lo  (fell_lo),
    .block_hi (block_hi),
    .block_lo (block_lo)
  );

  assign hs_stg = stg_cmd.hi;
  assign ls_stg = stg_cmd.lo;

endmodule

// File: rtl/dt_three_phase.sv
module dt_three_phase #(
  parameter int unsigned NUM_PHASES  = 3,
  parameter int unsigned DT_CYCLES   = 29,
  parameter int unsigned PIPE_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] hin,
  input  logic [NUM_PHASES-1:0] lin,
  output logic [NUM_PHASES-1:0] ho_en,
  output logic [NUM_PHASES-1:0] lo_en
);

  // Staged commands, brought out for the checker.
  logic [NUM_PHASES-1:0] hs_stg_v;
  logic [NUM_PHASES-1:0] ls_stg_v;

  generate
    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
      dt_leg #(
        .DT_CYCLES   (DT_CYCLES),
        .PIPE_STAGES (PIPE_STAGES)
      ) u_leg (
        .clk    (clk),
        .rst_n  (rst_n),
        .hin    (hin[p]),
        .lin    (lin[p]),
        .ho_en  (ho_en[p]),
        .lo_en  (lo_en[p]),
        .hs_stg (hs_stg_v[p]),
        .ls_stg (ls_stg_v[p])
      );
    end
  endgenerate

endmodule

// File: rtl/dt_three_phase_chk.sv
module dt_three_phase_chk
  import dt_pkg::*;
#(
  parameter int unsigned NUM_PHASES = 3,
  parameter int unsigned DT_CYCLES  = 29
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PHASES-1:0] ho_en,
  input logic [NUM_PHASES-1:0] lo_en,
  input logic [NUM_PHASES-1:0] hs_stg_v,
  input logic [NUM_PHASES-1:0] ls_stg_v
);

  localparam int unsigned CW = cnt_width(DT_CYCLES);
  localparam logic [CW-1:0] DT_SAT = CW'(DT_CYCLES);

  generate
    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_chk
      logic [CW-1:0] since_lo;
      logic [CW-1:0] since_hi;

      // Cycles since each enable was last on, saturating at the deadtime.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          since_lo <= DT_SAT;
          since_hi <= DT_SAT;
        end else begin
          if (lo_en[p])               since_lo <= '0;
          else if (since_lo != DT_SAT) since_lo <= since_lo + 1'b1;
          if (ho_en[p])               since_hi <= '0;
          else if (since_hi != DT_SAT) since_hi <= since_hi + 1'b1;
        end
      end

      p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ho_en[p] && lo_en[p]));

      p_dt_before_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ho_en[p]) |-> (since_lo >= DT_SAT));

      p_dt_before_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_en[p]) |-> (since_hi >= DT_SAT));

      p_both_cmd_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_stg_v[p] && ls_stg_v[p]) |=> (!ho_en[p] && !lo_en[p]));

      p_hi_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_stg_v[p] |=> !ho_en[p]);

      p_lo_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_stg_v[p] |=> !lo_en[p]);
    end
  endgenerate

endmodule

bind dt_three_phase dt_three_phase_chk #(
  .NUM_PHASES (NUM_PHASES),
  .DT_CYCLES  (DT_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ho_en    (ho_en),
  .lo_en    (lo_en),
  .hs_stg_v (hs_stg_v),
  .ls_stg_v (ls_stg_v)
);

// File: tb/sim_dt_three_phase.sv
`timescale 1ns/1ps
module sim_dt_three_phase;
  localparam int NP  = 3;
  localparam int DT  = 5;
  localparam int PS  = 2;
  localparam int LAT = PS + 1;

  logic          clk   = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] hin   = '0;
  logic [NP-1:0] lin   = '0;
  logic [NP-1:0] ho_en;
  logic [NP-1:0] lo_en;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;
  int  cyc   = 0;
  int  overlap = 0;
  int  t_hr[NP];
  int  t_hf[NP];
  int  t_lr[NP];
  int  t_lf[NP];
  logic [NP-1:0] pho = '0;
  logic [NP-1:0] plo = '0;

  always #2.5 clk = ~clk;

  dt_three_phase #(
    .NUM_PHASES  (NP),
    .DT_CYCLES   (DT),
    .PIPE_STAGES (PS)
  ) u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .hin   (hin),
    .lin   (lin),
    .ho_en (ho_en),
    .lo_en (lo_en)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Edge recorder: the cycle number at which each enable edge is seen.
  initial for (int p = 0; p < NP; p++) begin
    t_hr[p] = -1; t_hf[p] = -1; t_lr[p] = -1; t_lf[p] = -1;
  end

  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (ho_en[p] && !pho[p]) t_hr[p] = cyc;
      if (!ho_en[p] && pho[p]) t_hf[p] = cyc;
      if (lo_en[p] && !plo[p]) t_lr[p] = cyc;
      if (!lo_en[p] && plo[p]) t_lf[p] = cyc;
      if (rst_n && ho_en[p] && lo_en[p]) overlap++;
    end
    pho = ho_en;
    plo = lo_en;
  end

  function automatic int want_gap(input int g);
    return (g < DT) ? DT : g;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  localparam int SETTLE = DT + LAT + 4;

  initial begin
    int n;
    int m;
    idle(3);
    // R10: reset state
    chk("R10 ho_en in reset", int'(ho_en), 0);
    chk("R10 lo_en in reset", int'(lo_en), 0);
    rst_n = 1'b1;
    idle(2);

    // R3/R10: latency of each edge on each side
    hin[0] = 1'b1; n = cyc; idle(SETTLE);
    chk("R10 R3 ho rise latency", t_hr[0] - n, LAT);
    hin[0] = 1'b0; n = cyc; idle(SETTLE);
    chk("R3 ho fall latency", t_hf[0] - n, LAT);
    lin[0] = 1'b1; n = cyc; idle(SETTLE);
    chk("R3 lo rise latency", t_lr[0] - n, LAT);
    lin[0] = 1'b0; n = cyc; idle(SETTLE);
    chk("R3 lo fall latency", t_lf[0] - n, LAT);

    // R2/R9: truth table, each leg on a different code
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < NP; p++) begin
        int code;
        code = (c + p) % 4;
        hin[p] = code[1];
        lin[p] = code[0];
      end
      idle(SETTLE + DT);
      for (int p = 0; p < NP; p++) begin
        int code;
        code = (c + p) % 4;
        chk($sformatf("R2 R9 ho leg%0d code%0d", p, code), int'(ho_en[p]),
            int'(code == 2));
        chk($sformatf("R2 R9 lo leg%0d code%0d", p, code), int'(lo_en[p]),
            int'(code == 1));
      end
    end
    hin = '0; lin = '0; idle(SETTLE);

    // R4/R5: commanded gap sweep in both directions
    for (int g = 0; g <= DT + 3; g++) begin
      string tag;
      tag = (g < DT) ? "R4" : "R5";
      hin[0] = 1'b0; lin[0] = 1'b1; idle(SETTLE);
      lin[0] = 1'b0; n = cyc; idle(g); hin[0] = 1'b1; idle(SETTLE + g);
      chk($sformatf("%s lo fall g=%0d", tag, g), t_lf[0] - n, LAT);
      chk($sformatf("%s lo->hi gap g=%0d", tag, g), t_hr[0] - t_lf[0], want_gap(g));
      hin[0] = 1'b0; idle(g); lin[0] = 1'b1; idle(SETTLE + g);
      chk($sformatf("%s hi->lo gap g=%0d", tag, g), t_lr[0] - t_hf[0], want_gap(g));
    end

    // R6: overlapped commands while low side is on
    for (int i = 0; i < 2; i++) begin
      int k;
      k = (i == 0) ? 2 : DT + 3;
      hin[0] = 1'b0; lin[0] = 1'b1; idle(SETTLE);
      hin[0] = 1'b1; n = cyc; idle(k);
      if (k >= LAT + 1) begin
        chk("R6 both off during overlap", int'(ho_en[0]) + int'(lo_en[0]), 0);
      end
      lin[0] = 1'b0; idle(SETTLE + k);
      chk($sformatf("R6 lo fall k=%0d", k), t_lf[0] - n, LAT);
      chk($sformatf("R6 gap k=%0d", k), t_hr[0] - t_lf[0], want_gap(k));
    end
    hin = '0; lin = '0; idle(SETTLE);

    // R7: simultaneous rise from both-off
    hin[1] = 1'b1; lin[1] = 1'b1; n = cyc; idle(SETTLE);
    chk("R7 ho stays off", int'(ho_en[1]), 0);
    chk("R7 lo stays off", int'(lo_en[1]), 0);
    chk("R7 no ho edge", int'(t_hr[1] > n), 0);
    lin[1] = 1'b0; m = cyc; idle(SETTLE);
    chk("R7 ho after release", t_hr[1] - m, LAT);

    // R8: one-cycle off pulse on the same side
    hin[1] = 1'b0; n = cyc; idle(1); hin[1] = 1'b1; idle(SETTLE);
    chk("R8 ho fall", t_hf[1] - n, LAT);
    chk("R8 ho off width", t_hr[1] - t_hf[1], 1);
    lin[2] = 1'b1; idle(SETTLE);
    lin[2] = 1'b0; n = cyc; idle(1); lin[2] = 1'b1; idle(SETTLE);
    chk("R8 lo off width", t_lr[2] - t_lf[2], 1);
    chk("R9 leg1 ho held", int'(ho_en[1]), 1);
    hin = '0; lin = '0; idle(SETTLE);

    // R1: no overlap seen over the whole run
    chk("R1 overlap cycles", overlap, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule